// File: doc/BRIEF.md
# Banked change-of-state interrupt controller

This block watches a wide group of digital input lines and tells a host when any of them toggles. The lines are split into banks of eight. Each line is brought into the clock domain through a synchroniser, and a transition in either direction on any line of a bank raises that bank's sticky flag, provided the host has enabled the bank. While any flag is set, a single level interrupt output stays high.

The host reaches the block over a small synchronous register port. It has a 3-bit address, 8-bit write and read data, and one-cycle read and write strobes. Read data is registered and appears on the cycle after the strobe. Six byte offsets return the synchronised input bytes. One offset returns zero. The top offset is the control point: reading it returns a status byte and clears every flag, and writing it loads the per-bank enable mask.

The host normally enables the banks it cares about and waits for the interrupt. It then reads the status byte to learn which banks moved and reads those banks' input bytes to see the new line levels.

Top module: `cos_irq_ctrl`

## Requirements
- R1: Bank n holds lines 8n to 8n+7, with line 8n+k at bit k. Banks 0 to 2 are read at offsets 0 to 2 and banks 3 to 5 at offsets 4 to 6. Each of these reads returns the synchronised level of the bank's eight lines.
- R2: A read of offset 3 returns 0x00.
- R3: A rising or falling edge on any line of an enabled bank sets that bank's flag. If the line changes just before clock edge k, the flag and `irq` rise at edge k+2, not before.
- R4: A change on a line whose bank enable bit is 0 leaves that bank's flag clear.
- R5: A read of offset 7 returns a status byte. Bits 5:0 hold the bank flags, bit 6 is 0 exactly when a flag is pending, and bit 7 is 1 when any enable bit is set.
- R6: A read of offset 7 clears every bank flag, so `irq` falls on the same clock edge.
- R7: A bank change that is detected on the same edge as a clearing status read keeps its bank flag set after that edge.
- R8: A write to offset 7 loads `wr_data[5:0]` as the bank enable mask. Writes to offsets 0 to 6 change nothing.
- R9: After reset the enable mask and all flags are zero, `irq` is low and `rd_data` is 0x00.
- R10: `irq` is high exactly while at least one bank flag is set.
- R11: A bank flag stays set after its lines return to their old levels, until a status read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 48 | Raw input lines, bank n on bits 8n+7:8n |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | One-cycle read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt, high while any bank flag is set |

## Verification
A wrong edge register or synchroniser stage shows up as `irq` rising one edge early or late, or as a flag in a neighbouring bank. The bench catches both, because it steps every line through a rise and a fall and checks `irq` both at the edge before and at the edge of its expected rise. A mask or clear fault shows in the very next status read: a flag appears for a disabled bank, a flag survives the clear, or a flag that was raised on the clearing edge is missing. Sweeping all 64 mask values exposes any bit of the enable register that is stuck or miswired within one read.

// File: rtl/cos_pkg.sv
package cos_pkg;
   localparam int unsigned ADDR_W   = 3;
   localparam int unsigned DATA_W   = 8;
   localparam int unsigned PEND_BIT = 6;
   localparam int unsigned EN_BIT   = 7;
   localparam logic [ADDR_W-1:0] OFS_HOLE   = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd7;

   // Byte offset to bank index: offsets above the hole shift down by one.
   function automatic int unsigned bank_of(input logic [ADDR_W-1:0] a);
      return (a < OFS_HOLE) ? int'(a) : int'(a) - 1;
   endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int unsigned WIDTH  = 48,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cos_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cos_bank_edge.sv
module cos_bank_edge #(
   parameter int unsigned NUM_BANKS = 6,
   parameter int unsigned BANK_W    = 8,
   localparam int unsigned LINES    = NUM_BANKS * BANK_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LINES-1:0]     cur,
   output logic [NUM_BANKS-1:0] bank_chg
);
   logic [LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
   end

   // Any difference in either direction counts as a change for the bank.
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_chg[b] = |(cur[b*BANK_W +: BANK_W] ^ prev_q[b*BANK_W +: BANK_W]);

      AST_EDGE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
         (cur[b*BANK_W +: BANK_W] != prev_q[b*BANK_W +: BANK_W]) |=>
            (prev_q[b*BANK_W +: BANK_W] == $past(cur[b*BANK_W +: BANK_W]))); // R3
   end
endmodule

// File: rtl/cos_flag_regs.sv
module cos_flag_regs #(
   parameter int unsigned NUM_BANKS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_chg,
   input  logic                 clr,
   input  logic                 mask_we,
   input  logic [NUM_BANKS-1:0] mask_wdata,
   output logic [NUM_BANKS-1:0] flags,
   output logic [NUM_BANKS-1:0] mask
);
   logic [NUM_BANKS-1:0] hits;
   logic [NUM_BANKS-1:0] flags_d;

   assign hits = bank_chg & mask;

   // A change seen on the clearing edge is OR-ed in after the clear.
   always_comb begin
      flags_d = clr ? '0 : flags;
      flags_d = flags_d | hits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         mask  <= '0;
      end else begin
         flags <= flags_d;
         if (mask_we) mask <= mask_wdata;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[b] && !clr) |=> flags[b]); // R11
      AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (!flags[b] && !mask[b]) |=> !flags[b]); // R4
      AST_CHANGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && bank_chg[b] && mask[b]) |=> flags[b]); // R7
   end

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (hits == '0)) |=> (flags == '0)); // R6
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
   parameter int unsigned NUM_BANKS   = 6,
   parameter int unsigned BANK_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned LINES      = NUM_BANKS * BANK_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   input  logic [2:0]       addr,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             irq
);
   import cos_pkg::*;

   generate
      if (BANK_W != DATA_W) begin : g_bad_width
         $error("bank width must equal the data byte width");
      end
      if (NUM_BANKS < 1 || NUM_BANKS > PEND_BIT) begin : g_bad_banks
         $error("bank count must fit below the pending bit");
      end
   endgenerate

   logic [LINES-1:0]     din_s;
   logic [NUM_BANKS-1:0] bank_chg;
   logic [NUM_BANKS-1:0] flags;
   logic [NUM_BANKS-1:0] mask;
   logic                 status_rd;
   logic                 mask_we;
   logic [DATA_W-1:0]    status;
   logic [DATA_W-1:0]    rd_next;

   cos_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
   );

   cos_bank_edge #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .cur(din_s), .bank_chg(bank_chg)
   );

   assign status_rd = rd_en && (addr == OFS_STATUS);
   assign mask_we   = wr_en && (addr == OFS_STATUS);

   cos_flag_regs #(.NUM_BANKS(NUM_BANKS)) u_flags (
      .clk(clk), .rst_n(rst_n), .bank_chg(bank_chg), .clr(status_rd),
      .mask_we(mask_we), .mask_wdata(wr_data[NUM_BANKS-1:0]),
      .flags(flags), .mask(mask)
   );

   assign irq = |flags;

   always_comb begin
      status                  = '0;
      status[NUM_BANKS-1:0]   = flags;
      status[PEND_BIT]        = ~irq;
      status[EN_BIT]          = |mask;
   end

   always_comb begin
      rd_next = '0;
      if (addr == OFS_STATUS) begin
         rd_next = status;
      end else if (addr != OFS_HOLE) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_of(addr) == b) rd_next = din_s[b*BANK_W +: BANK_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask)); // R8
   AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == OFS_HOLE) |=> (rd_data == 8'h00)); // R2
   AST_PEND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && irq) |=> !rd_data[PEND_BIT]); // R5
   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past((bank_chg & mask) != '0)); // R10
endmodule

// File: tb/tb_cos_irq_ctrl.sv
`timescale 1ns/1ps
module tb_cos_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] din = '0;
   logic [2:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_data;
   logic        irq;
   logic [7:0]  rv;
   int          checks = 0;
   int          errors = 0;

   always #5 clk = ~clk;

   cos_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [2:0] ofs(input int b);
      return (b < 3) ? 3'(b) : 3'(b + 1);
   endfunction

   initial begin
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      check("R9 rd_data after reset", rd_data, 8'h00);
      check("R9 irq after reset", {7'd0, irq}, 8'h00);
      rd(3'd7, rv);
      check("R9 R5 status after reset", rv, 8'h40);

      // Every line through a rise and a fall with all banks enabled.
      wr(3'd7, 8'h3F);
      for (int b = 0; b < 6; b++) begin
         for (int l = 0; l < 8; l++) begin
            for (int ph = 0; ph < 2; ph++) begin
               din[b*8+l] = ~din[b*8+l];
               cyc(2);
               check("R3 irq not before latency", {7'd0, irq}, 8'h00);
               cyc(1);
               check("R3 R10 irq at latency", {7'd0, irq}, 8'h01);
               rd(ofs(b), rv);
               check("R1 bank byte", rv, (ph == 0) ? 8'(1 << l) : 8'h00);
               rd(3'd7, rv);
               check("R5 status bank flag", rv, 8'h80 | 8'(1 << b));
               check("R6 irq after clear", {7'd0, irq}, 8'h00);
            end
         end
      end

      // All mask values, one line toggled in every bank at once.
      for (int m = 0; m < 64; m++) begin
         wr(3'd7, 8'(m));
         din = din ^ {6{8'(1 << (m % 8))}};
         cyc(3);
         check("R4 R10 irq under mask", {7'd0, irq}, (m != 0) ? 8'h01 : 8'h00);
         rd(3'd7, rv);
         check("R4 R5 masked status", rv, 8'(m) | ((m == 0) ? 8'h40 : 8'h80));
      end

      // Raw bytes and the hole.
      din = 48'hA5_3C_F0_0F_96_FF;
      cyc(3);
      for (int b = 0; b < 6; b++) begin
         rd(ofs(b), rv);
         check("R1 pattern byte", rv, din[b*8 +: 8]);
      end
      rd(3'd3, rv);
      check("R2 hole reads zero", rv, 8'h00);
      rd(3'd7, rv);

      // Writes elsewhere leave the mask alone.
      wr(3'd7, 8'h3F);
      for (int a = 0; a < 7; a++) wr(3'(a), 8'h00);
      rd(3'd7, rv);
      check("R8 mask kept", rv, 8'hC0);
      din[47] = ~din[47];
      cyc(3);
      rd(3'd7, rv);
      check("R8 bank 5 still enabled", rv, 8'hA0);

      // Sticky flag after the line returns.
      din[0] = ~din[0];
      cyc(2);
      din[0] = ~din[0];
      cyc(8);
      check("R11 flag held", {7'd0, irq}, 8'h01);
      rd(3'd7, rv);
      check("R11 status held", rv, 8'h81);

      // Change on the clearing edge survives.
      din[3] = ~din[3];
      cyc(3);
      din[9] = ~din[9];
      cyc(2);
      rd(3'd7, rv);
      check("R7 read shows old flag", rv, 8'h81);
      check("R7 irq kept", {7'd0, irq}, 8'h01);
      rd(3'd7, rv);
      check("R7 new flag kept", rv, 8'h82);
      rd(3'd7, rv);
      check("R6 all clear", rv, 8'hC0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule